// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block adds two unsigned binary words and an input carry in pure combinational logic. The word is cut into equal slices of four bits. Each slice works out its own internal bit carries with a local lookahead network. It also reports whether it creates a carry by itself (slice generate) and whether it would pass an incoming carry straight through (slice propagate).

A second lookahead network takes the slice generate and propagate pairs and the input carry. From them it forms the carry into every upper slice and the final carry out. Each of those carries is a flat OR of AND terms, so no carry ripples from one slice to the next. The widest term, the final carry out, has five inputs for four slices. The longest path runs about ten gate levels: five to form the carry into the top slice and five more inside that slice to reach the top sum bit.

The adder has no clock and no state. The result appears on the outputs in the same evaluation as the operands. The slice width and the slice count are parameters, and by default they give a 16-bit adder.

Top module: `gcla_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i`, taken as unsigned binary values.
- R2: `cout_o` equals bit 16 of `a_i + b_i + cin_i`.
- R3: A 4-bit slice in which every bit position has exactly one operand bit set passes its incoming carry unchanged to the next slice; with `a_i = 16'hF0F0`, `b_i = 16'h0F0F` the result is `sum_o = 16'h0000, cout_o = 1` when `cin_i = 1` and `sum_o = 16'hFFFF, cout_o = 0` when `cin_i = 0`.
- R4: A slice that generates a carry delivers it to the next slice whatever its incoming carry is, and a slice never reports generate and propagate together; `16'hF000 + 16'h1000` gives `cout_o = 1` with either `cin_i` value.
- R5: The carry into slice k+1 equals slice k generate OR (slice k propagate AND carry into slice k), for slices 0 to 3 (slice 0 holds bits 3:0), with the carry into slice 0 equal to `cin_i`; a carry generated in slice 0 crosses propagating slices 1 and 2 (`16'h0FFF + 16'h0001 = 16'h1000`).
- R6: All-ones plus an input carry of 1 gives `sum_o = 16'h0000` and `cout_o = 1`.
- R7: Zero plus zero with `cin_i = 0` gives `sum_o = 16'h0000` and `cout_o = 0`.
- R8: The outputs follow the inputs with no clock; a change of operands shows on `sum_o` and `cout_o` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into the least significant bit |
| sum_o | output | 16 | Sum, low 16 bits |
| cout_o | output | 1 | Carry out of the most significant bit |

## Verification
The bench goes after carries that have to cross whole slices. These are the full propagate chain of all-ones plus one and a carry generated low that must jump over propagating middle slices. A second-level term that was dropped or wrongly indexed would leave an upper slice without its carry and give a sum off by a power of 16. A slice propagate built from the wrong bits would either lose the input carry or invent a carry, which shows up in the alternating-nibble pattern under both `cin_i` values. A generate term tied to the input carry would make the top-slice carry out depend on `cin_i`. Random operands over the whole range catch the errors that remain in the per-bit lookahead inside a slice.

// File: rtl/gcla_pkg.sv
package gcla_pkg;
  // Default geometry of the adder: slice width and slice count.
  parameter int unsigned GCLA_GRP_W = 4;
  parameter int unsigned GCLA_GRP_N = 4;
endpackage

// File: rtl/cla_carry_net.sv
// Flattened lookahead: every carry c[k] is an OR of AND terms built directly
// from generate/propagate inputs and the entry carry; no carry feeds another.
module cla_carry_net #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N:1]   carry_o
);
  for (genvar k = 1; k <= N; k++) begin : g_carry
    logic c_k;
    always_comb begin
      logic acc;
      logic term;
      acc = cin_i & (&prop_i[k-1:0]);
      for (int j = 0; j < k; j++) begin
        term = gen_i[j];
        for (int m = j + 1; m < k; m++) begin
          term = term & prop_i[m];
        end
        acc = acc | term;
      end
      c_k = acc;
    end
    assign carry_o[k] = c_k;
  end
endmodule

// File: rtl/cla_span_pg.sv
// Span generate and propagate of a group of positions, in flat form.
module cla_span_pg #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  output logic         span_g_o,
  output logic         span_p_o
);
  always_comb begin
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = gen_i[j];
      for (int m = j + 1; m < N; m++) begin
        term = term & prop_i[m];
      end
      acc = acc | term;
    end
    span_g_o = acc;
  end

  assign span_p_o = &prop_i;
endmodule

// File: rtl/cla_group.sv
// One slice: bit generate/propagate, local lookahead, slice pg and sum bits.
module cla_group #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         grp_g_o,
  output logic         grp_p_o
);
  logic [W-1:0] bit_g;
  logic [W-1:0] bit_p;
  logic [W-1:1] bit_c;
  logic [W-1:0] carry_in_vec;

  assign bit_g = a_i & b_i;
  assign bit_p = a_i ^ b_i;

  // Carries into bits 1..W-1 depend only on bits 0..W-2.
  cla_carry_net #(.N(W - 1)) u_local (
    .gen_i   (bit_g[W-2:0]),
    .prop_i  (bit_p[W-2:0]),
    .cin_i   (cin_i),
    .carry_o (bit_c)
  );

  cla_span_pg #(.N(W)) u_span (
    .gen_i    (bit_g),
    .prop_i   (bit_p),
    .span_g_o (grp_g_o),
    .span_p_o (grp_p_o)
  );

  assign carry_in_vec = {bit_c, cin_i};
  assign sum_o        = bit_p ^ carry_in_vec;
endmodule

// File: rtl/gcla_adder.sv
module gcla_adder #(
  parameter int unsigned GRP_W = gcla_pkg::GCLA_GRP_W,
  parameter int unsigned GRP_N = gcla_pkg::GCLA_GRP_N,
  localparam int unsigned WIDTH = GRP_W * GRP_N
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [GRP_N-1:0] grp_g;
  logic [GRP_N-1:0] grp_p;
  logic [GRP_N:0]   grp_c;
  logic [GRP_N:1]   grp_c_up;

  for (genvar k = 0; k < GRP_N; k++) begin : g_slice
    cla_group #(.W(GRP_W)) u_grp (
      .a_i     (a_i[k*GRP_W +: GRP_W]),
      .b_i     (b_i[k*GRP_W +: GRP_W]),
      .cin_i   (grp_c[k]),
      .sum_o   (sum_o[k*GRP_W +: GRP_W]),
      .grp_g_o (grp_g[k]),
      .grp_p_o (grp_p[k])
    );
  end

  // Second level: carries into every upper slice and out, each flat.
  cla_carry_net #(.N(GRP_N)) u_level2 (
    .gen_i   (grp_g),
    .prop_i  (grp_p),
    .cin_i   (cin_i),
    .carry_o (grp_c_up)
  );

  assign grp_c  = {grp_c_up, cin_i};
  assign cout_o = grp_c[GRP_N];
endmodule

// File: rtl/gcla_adder_chk.sv
module gcla_adder_chk #(
  parameter int unsigned GRP_W = 4,
  parameter int unsigned GRP_N = 4,
  localparam int unsigned WIDTH = GRP_W * GRP_N
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic [GRP_N-1:0] grp_g,
  input logic [GRP_N-1:0] grp_p,
  input logic [GRP_N:0]   grp_c
);
  logic [WIDTH:0] ref_total;
  logic           known;

  assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
  assign known     = !$isunknown({a_i, b_i, cin_i});

  always_comb begin
    if (known) begin
      assert_sum_exact_R1: assert (sum_o == ref_total[WIDTH-1:0]);
      assert_carry_out_R2: assert (cout_o == ref_total[WIDTH]);
      for (int k = 0; k < GRP_N; k++) begin
        assert_slice_chain_R5: assert (grp_c[k+1] == (grp_g[k] | (grp_p[k] & grp_c[k])));
        assert_gen_prop_excl_R4: assert (!(grp_g[k] && grp_p[k]));
        if (grp_p[k]) begin
          assert_prop_pass_R3: assert (grp_c[k+1] == grp_c[k]);
        end
      end
      if (a_i == '0 && b_i == '0 && !cin_i) begin
        assert_zero_R7: assert (sum_o == '0 && !cout_o);
      end
    end
  end
endmodule

bind gcla_adder gcla_adder_chk #(.GRP_W(GRP_W), .GRP_N(GRP_N)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .grp_g  (grp_g),
  .grp_p  (grp_p),
  .grp_c  (grp_c)
);

// File: tb/tb_gcla_adder.sv
`timescale 1ns/1ps
module tb_gcla_adder;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic         cin;
  logic [W-1:0] sum;
  logic         cout;
  int           n_checks;
  int           n_fails;
  bit           done;

  gcla_adder dut (
    .a_i    (a),
    .b_i    (b),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [W:0] ref_add(logic [W-1:0] x, logic [W-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic compare(string tag);
    logic [W:0] exp;
    exp = ref_add(a, b, cin);
    n_checks++;
    if (sum !== exp[W-1:0]) begin
      n_fails++;
      $display("FAIL %s sum: a=%h b=%h cin=%0b actual=%h expected=%h", tag, a, b, cin, sum, exp[W-1:0]);
    end
    n_checks++;
    if (cout !== exp[W]) begin
      n_fails++;
      $display("FAIL %s cout: a=%h b=%h cin=%0b actual=%0b expected=%0b", tag, a, b, cin, cout, exp[W]);
    end
  endtask

  task automatic apply(logic [W-1:0] x, logic [W-1:0] y, logic c, string tag);
    @(posedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic expect_fixed(logic [W-1:0] es, logic ec, string tag);
    n_checks++;
    if (sum !== es || cout !== ec) begin
      n_fails++;
      $display("FAIL %s: actual=%0b/%h expected=%0b/%h", tag, cout, sum, ec, es);
    end
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    a = '0; b = '0; cin = 1'b0;
    @(negedge clk);
    compare("R7 initial zero");
    expect_fixed(16'h0000, 1'b0, "R7 zero plus zero");

    apply(16'hFFFF, 16'h0000, 1'b1, "R6 all ones plus cin");
    expect_fixed(16'h0000, 1'b1, "R6 all ones plus cin");
    apply(16'hFFFF, 16'h0001, 1'b0, "R6 all ones plus one");
    expect_fixed(16'h0000, 1'b1, "R6 all ones plus one");

    apply(16'hF0F0, 16'h0F0F, 1'b1, "R3 propagate all slices cin1");
    expect_fixed(16'h0000, 1'b1, "R3 propagate all slices cin1");
    apply(16'hF0F0, 16'h0F0F, 1'b0, "R3 propagate all slices cin0");
    expect_fixed(16'hFFFF, 1'b0, "R3 propagate all slices cin0");

    apply(16'hF000, 16'h1000, 1'b0, "R4 top generate cin0");
    expect_fixed(16'h0000, 1'b1, "R4 top generate cin0");
    apply(16'hF000, 16'h1000, 1'b1, "R4 top generate cin1");
    expect_fixed(16'h0001, 1'b1, "R4 top generate cin1");
    apply(16'h000F, 16'h0001, 1'b1, "R4 slice0 generate");

    apply(16'h0FFF, 16'h0001, 1'b0, "R5 carry skips slices");
    expect_fixed(16'h1000, 1'b0, "R5 carry skips slices");
    apply(16'h00FF, 16'h0001, 1'b0, "R5 carry into slice2");
    apply(16'h0F00, 16'h0100, 1'b0, "R5 carry into slice3");

    // R8: no clock edge between operand change and observation.
    @(negedge clk);
    a = 16'h1234; b = 16'h4321; cin = 1'b1;
    #1;
    expect_fixed(16'h5556, 1'b0, "R8 no clock response");
    a = 16'h8000; b = 16'h8000; cin = 1'b0;
    #1;
    expect_fixed(16'h0000, 1'b1, "R8 no clock response msb");

    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] x;
      logic [W-1:0] y;
      logic c;
      x = W'($urandom);
      y = W'($urandom);
      c = 1'($urandom);
      // Bias some vectors toward long propagate runs.
      if (i % 4 == 1) y = ~x ^ W'(1 << ($urandom % W));
      if (i % 4 == 2) y = ~x;
      apply(x, y, c, "R1 R2 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule